// File: doc/BRIEF.md
# Byte-paced I2C master

A single-master I2C controller driven through an 8-bit control register and an 8-bit byte register. Software places a slave address in the byte register and sets the run bit. The core then issues a start condition and shifts the address out MSB first. It samples the slave's acknowledge and parks with SCL held low. Every further byte, whether sent or received, begins only when software writes the run bit as 1 again. Bit 0 of the most recent address byte sets the direction of the data bytes that follow.

Software ends or redirects a transfer with two self-clearing request bits in the control register. One requests a stop condition and the other a repeated start, which sends the byte register again as a fresh address. Writing the run bit as 0 drops the bus at once. On received bytes the core drives an acknowledge level that software chooses in advance. SCL is made from a fixed divider: each bit takes four phases of `DIV` clock cycles. The outputs act as open drain, so 1 releases the line. Slave clock stretching and arbitration are not handled.

Top module: `i2cm_core`

## Requirements
- R1: After reset the control register reads 0x00, `busy_o` and `wait_o` are low, and `scl_o` and `sda_o` are both 1 (released). Whenever the core is not busy, both lines stay released.
- R2: The control register sits at `reg_addr_i`=0 and the byte register at `reg_addr_i`=1. With the core idle and `en_i` high, writing control bit 0 (run) as 1 sets `busy_o`. SDA then falls while SCL is high, and the byte register is shifted out MSB first.
- R3: A control write with run=1 while `en_i` is low leaves run at 0 and the core idle.
- R4: After every acknowledge bit the core enters a wait state: `wait_o`=1 and SCL held low. It stays there until a control write with run=1. That write starts the next byte, taken from the byte register when transmitting.
- R5: Control bit 1 (stop request) always reads 0. Writing it as 1 while busy clears run and makes SDA rise while SCL is high. The core then returns to idle.
- R6: Control bit 2 (restart request) always reads 0. It acts only in a write with run=1 while run is already 1. It then produces a repeated start (SDA falling with SCL high) and sends the byte register as a new address. While run is 0 it has no effect.
- R7: On a transmitted byte, the SDA level sampled during the acknowledge bit is presented on `ack_rx_o` (0 = ACK, 1 = NACK).
- R8: When bit 0 of the last address byte is 1, the following data bytes are received MSB first with SDA released. Each received byte is then readable from the byte register. When that bit is 0, data bytes are transmitted.
- R9: On a received byte, the core drives the acknowledge bit to the value of control bit 7 from the last control write (0 = ACK, 1 = NACK).
- R10: A control write with run=0 and stop=0 while busy releases both lines and clears `busy_o` on the next clock.
- R11: A single write that sets stop, restart and run together produces a stop condition and no repeated start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Interface enable; gates the setting of run |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 = control register, 1 = byte register |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| scl_o | output | 1 | SCL drive, 1 = released |
| sda_o | output | 1 | SDA drive, 1 = released |
| sda_i | input | 1 | Sampled SDA bus level |
| wait_o | output | 1 | Stalled after an acknowledge |
| busy_o | output | 1 | Transfer in progress |
| ack_rx_o | output | 1 | Acknowledge captured from the slave |

## Verification
A bus-level slave model in the bench tracks start and stop conditions and collects every byte the master sends. It can acknowledge or refuse a byte, and it can return read data. The pattern runs a write address, a write data byte, and a byte the slave refuses: the first two tell ACK capture apart from NACK capture. A repeated start then switches direction with a read address, and two read bytes follow with opposite acknowledge settings. Comparing these shows that the read path and the chosen acknowledge level are independent. Stop alone, stop combined with restart, restart with run clear, start with enable low, and an abort in the middle of a byte each isolate one interlock.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int BYTE_W = 8;
  localparam int CTL_RUN  = 0;
  localparam int CTL_STOP = 1;
  localparam int CTL_RS   = 2;
  localparam int CTL_ACKV = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_BIT, ST_ACK, ST_WAIT, ST_STOP, ST_RSTART
  } eng_state_e;

  typedef struct packed {
    logic start;
    logic resume;
    logic restart;
    logic stop;
    logic abort;
  } eng_cmd_t;
endpackage

// File: rtl/i2cm_phase_timer.sv
module i2cm_phase_timer #(
  parameter int DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       run_i,
  output logic       tick_o,
  output logic [1:0] phase_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          last;

  assign last   = (cnt_q == CW'(DIV - 1));
  assign tick_o = run_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_o <= '0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      phase_o <= '0;
    end else if (run_i) begin
      if (last) begin
        cnt_q   <= '0;
        phase_o <= phase_o + 2'd1;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/i2cm_ctrl_reg.sv
module i2cm_ctrl_reg
  import i2cm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     we_i,
  input  logic     wr_run_i,
  input  logic     wr_stop_i,
  input  logic     wr_rs_i,
  input  logic     wr_ackv_i,
  input  logic     en_i,
  input  logic     idle_i,
  input  logic     wait_i,
  output eng_cmd_t cmd_o,
  output logic     run_o,
  output logic     ackv_o
);
  // stop beats abort beats restart beats resume/start
  always_comb begin
    cmd_o = '0;
    if (we_i) begin
      if (wr_stop_i)      cmd_o.stop  = !idle_i;
      else if (!wr_run_i) cmd_o.abort = !idle_i;
      else if (run_o) begin
        if (wr_rs_i) cmd_o.restart = 1'b1;
        else         cmd_o.resume  = wait_i;
      end else       cmd_o.start   = en_i && idle_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o  <= 1'b0;
      ackv_o <= 1'b0;
    end else if (we_i) begin
      ackv_o <= wr_ackv_i;
      if (wr_stop_i || !wr_run_i) run_o <= 1'b0;
      else if (cmd_o.start)       run_o <= 1'b1;
    end
  end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  eng_cmd_t          cmd_i,
  input  logic              ackv_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              sda_i,
  output logic              scl_o,
  output logic              sda_o,
  output logic              idle_o,
  output logic              wait_o,
  output logic              ack_rx_o,
  output logic              rx_done_o,
  output logic [BYTE_W-1:0] rx_byte_o
);
  localparam int BW = $clog2(BYTE_W);

  eng_state_e      st_q;
  logic [BW-1:0]   bit_q;
  logic [BYTE_W-1:0] sh_q;
  logic            first_q, rd_q, smp_q;
  logic            tick, end_ph, mid_ph, rx_mode, scl_hi;
  logic [1:0]      phase;
  logic            go_abort, go_stop, go_rs, go_start, go_res, jump, t_run;

  assign go_abort = cmd_i.abort;
  assign go_stop  = cmd_i.stop;
  assign go_rs    = cmd_i.restart && st_q != ST_IDLE && st_q != ST_STOP;
  assign go_start = cmd_i.start && st_q == ST_IDLE;
  assign go_res   = cmd_i.resume && st_q == ST_WAIT;
  assign jump     = go_abort | go_stop | go_rs | go_start | go_res;
  assign t_run    = st_q != ST_IDLE && st_q != ST_WAIT;

  i2cm_phase_timer #(.DIV(DIV)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (jump),
    .run_i   (t_run),
    .tick_o  (tick),
    .phase_o (phase)
  );

  assign end_ph  = tick && phase == 2'd3;
  assign mid_ph  = tick && phase == 2'd2;
  assign rx_mode = rd_q && !first_q;
  assign scl_hi  = phase[0] ^ phase[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      bit_q     <= '0;
      sh_q      <= '0;
      first_q   <= 1'b0;
      rd_q      <= 1'b0;
      smp_q     <= 1'b1;
      ack_rx_o  <= 1'b0;
      rx_done_o <= 1'b0;
    end else begin
      rx_done_o <= 1'b0;
      if (go_abort)      st_q <= ST_IDLE;
      else if (go_stop)  st_q <= ST_STOP;
      else if (go_rs)    st_q <= ST_RSTART;
      else if (go_start) st_q <= ST_START;
      else if (go_res) begin
        st_q  <= ST_BIT;
        sh_q  <= tx_byte_i;
        bit_q <= BW'(BYTE_W - 1);
      end else begin
        if (mid_ph && st_q == ST_BIT) smp_q <= sda_i;
        if (mid_ph && st_q == ST_ACK && !rx_mode) ack_rx_o <= sda_i;
        if (end_ph) begin
          unique case (st_q)
            ST_START, ST_RSTART: begin
              st_q    <= ST_BIT;
              sh_q    <= tx_byte_i;
              bit_q   <= BW'(BYTE_W - 1);
              first_q <= 1'b1;
              rd_q    <= tx_byte_i[0];
            end
            ST_BIT: begin
              sh_q <= {sh_q[BYTE_W-2:0], smp_q};
              if (bit_q == '0) st_q <= ST_ACK;
              else             bit_q <= bit_q - BW'(1);
            end
            ST_ACK: begin
              st_q      <= ST_WAIT;
              first_q   <= 1'b0;
              rx_done_o <= rx_mode;
            end
            ST_STOP: st_q <= ST_IDLE;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    scl_o = 1'b1;
    sda_o = 1'b1;
    unique case (st_q)
      ST_START:  begin scl_o = !phase[1];  sda_o = (phase == 2'd0); end
      ST_RSTART: begin scl_o = scl_hi;     sda_o = !phase[1];       end
      ST_BIT:    begin scl_o = scl_hi;     sda_o = rx_mode | sh_q[BYTE_W-1]; end
      ST_ACK:    begin scl_o = scl_hi;     sda_o = rx_mode ? ackv_i : 1'b1; end
      ST_WAIT:   begin scl_o = 1'b0;       sda_o = 1'b0; end
      ST_STOP:   begin scl_o = (phase != 2'd0); sda_o = phase[1]; end
      default:   ;
    endcase
  end

  assign idle_o    = st_q == ST_IDLE;
  assign wait_o    = st_q == ST_WAIT;
  assign rx_byte_o = sh_q;
endmodule

// File: rtl/i2cm_core.sv
module i2cm_core
  import i2cm_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       reg_we_i,
  input  logic       reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       scl_o,
  output logic       sda_o,
  input  logic       sda_i,
  output logic       wait_o,
  output logic       busy_o,
  output logic       ack_rx_o
);
  eng_cmd_t          cmd;
  logic              run, ackv, idle, rx_done;
  logic [BYTE_W-1:0] rx_byte, data_q;
  logic [7:0]        ctl_rd;

  i2cm_ctrl_reg u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i && !reg_addr_i),
    .wr_run_i  (reg_wdata_i[CTL_RUN]),
    .wr_stop_i (reg_wdata_i[CTL_STOP]),
    .wr_rs_i   (reg_wdata_i[CTL_RS]),
    .wr_ackv_i (reg_wdata_i[CTL_ACKV]),
    .en_i      (en_i),
    .idle_i    (idle),
    .wait_i    (wait_o),
    .cmd_o     (cmd),
    .run_o     (run),
    .ackv_o    (ackv)
  );

  i2cm_engine #(.DIV(DIV)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd),
    .ackv_i    (ackv),
    .tx_byte_i (data_q),
    .sda_i     (sda_i),
    .scl_o     (scl_o),
    .sda_o     (sda_o),
    .idle_o    (idle),
    .wait_o    (wait_o),
    .ack_rx_o  (ack_rx_o),
    .rx_done_o (rx_done),
    .rx_byte_o (rx_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     data_q <= '0;
    else if (rx_done)                data_q <= rx_byte;
    else if (reg_we_i && reg_addr_i) data_q <= reg_wdata_i;
  end

  // request bits are never stored, so they read 0
  always_comb begin
    ctl_rd           = '0;
    ctl_rd[CTL_RUN]  = run;
    ctl_rd[CTL_ACKV] = ackv;
  end

  assign reg_rdata_o = reg_addr_i ? data_q : ctl_rd;
  assign busy_o      = !idle;
endmodule

// File: rtl/i2cm_core_chk.sv
module i2cm_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       reg_we_i,
  input logic       reg_addr_i,
  input logic [2:0] ctl_wd_i,
  input logic       scl_o,
  input logic       sda_o,
  input logic       wait_o,
  input logic       busy_o
);
  logic ctl_we;
  assign ctl_we = reg_we_i && !reg_addr_i;

  assert_idle_released_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (scl_o && sda_o));

  assert_start_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we && !en_i && !busy_o) |=> !busy_o);

  assert_wait_scl_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o |-> !scl_o);

  assert_wait_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_o && !ctl_we) |=> wait_o);

  assert_stop_enter_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we && ctl_wd_i[1] && busy_o) |=> (busy_o && !wait_o && !scl_o && !sda_o));

  assert_stop_over_restart_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we && ctl_wd_i[1] && ctl_wd_i[2] && ctl_wd_i[0] && busy_o) |=> (!sda_o && !scl_o));

  assert_abort_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we && !ctl_wd_i[1] && !ctl_wd_i[0] && busy_o) |=> (!busy_o && scl_o && sda_o));
endmodule

bind i2cm_core i2cm_core_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .ctl_wd_i   (reg_wdata_i[2:0]),
  .scl_o      (scl_o),
  .sda_o      (sda_o),
  .wait_o     (wait_o),
  .busy_o     (busy_o)
);

// File: tb/i2cm_core_tb_top.sv
`timescale 1ns/1ps
module i2cm_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       reg_we = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       scl_o, sda_o, wait_o, busy_o, ack_rx_o;
  logic       sl_sda = 1'b1;
  logic       sda_bus;

  assign sda_bus = sda_o & sl_sda;

  i2cm_core #(.DIV(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_bus),
    .wait_o(wait_o), .busy_o(busy_o), .ack_rx_o(ack_rx_o)
  );

  always #4 clk = ~clk;

  int applied = 0;
  int miscompares = 0;
  bit reported = 0;

  logic [7:0] exp_q[$];   // bytes the master must put on the bus
  logic [7:0] sl_tx_q[$]; // bytes the slave returns on reads

  int   n_start = 0, n_stop = 0;
  int   bc = 0;
  bit   is_addr = 0, rd_pend = 0, rd_data = 0, sl_nack = 0;
  logic mack = 1'b1;
  logic [7:0] shin = '0, txb = '0;
  logic p_scl = 1'b1, p_sda = 1'b1;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  endtask

  // slave model + scoreboard monitor
  initial begin
    forever begin
      logic cs, cd;
      @(negedge clk);
      cs = scl_o;
      cd = sda_bus;
      if (cs && p_scl && p_sda && !cd) begin
        n_start++; bc = 0; is_addr = 1; rd_data = 0; sl_sda = 1'b1;
      end else if (cs && p_scl && !p_sda && cd) begin
        n_stop++; bc = 0; rd_data = 0; sl_sda = 1'b1;
      end else if (cs && !p_scl) begin
        if (bc < 8 && !rd_data) shin = {shin[6:0], cd};
        if (bc == 8 && rd_data) mack = cd;
        bc++;
      end else if (!cs && p_scl) begin
        if (bc == 8) begin
          if (!rd_data) begin
            sl_sda = sl_nack;
            if (is_addr) rd_pend = shin[0];
            if (exp_q.size() == 0) check("R2 unexpected byte", shin, 8'hxx);
            else check("R2/R4 bus byte", shin, exp_q.pop_front());
          end else sl_sda = 1'b1;
        end else if (bc == 9) begin
          bc = 0;
          if (is_addr) begin is_addr = 0; rd_data = rd_pend; end
          else if (rd_data && mack) rd_data = 0;
          if (rd_data && sl_tx_q.size() > 0) begin
            txb = sl_tx_q.pop_front(); sl_sda = txb[7];
          end else begin
            rd_data = 0; sl_sda = 1'b1;
          end
        end else if (bc >= 1 && bc < 8 && rd_data) sl_sda = txb[7-bc];
      end
      p_scl = cs;
      p_sda = cd;
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_stall(input string tag);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (wait_o) return;
    end
    check({tag, " stall timeout"}, 8'h0, 8'h1);
  endtask

  task automatic wait_idle(input string tag);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!busy_o) return;
    end
    check({tag, " idle timeout"}, 8'h1, 8'h0);
  endtask

  // driver: expected bus byte goes to the scoreboard, then the core is paced
  task automatic send(input logic [7:0] b, input logic [7:0] ctl);
    exp_q.push_back(b);
    wr(1'b1, b);
    wr(1'b0, ctl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog all-reqs actual=running expected=finished");
    report();
  end

  initial begin
    logic [7:0] r;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(1'b0, r);
    check("R1 ctrl reset", r, 8'h00);
    check("R1 lines/status", {4'h0, scl_o, sda_o, busy_o, wait_o}, 8'h0C);

    // R3: enable low blocks start
    wr(1'b0, 8'h01);
    rd(1'b0, r);
    check("R3 run stays 0", r, 8'h00);
    check("R3 still idle", {7'h0, busy_o}, 8'h00);

    // R2: address write byte, slave ACKs
    en = 1'b1;
    send(8'hA4, 8'h01);
    check("R2 busy after run", {7'h0, busy_o}, 8'h01);
    wait_stall("R2");
    check("R2 one start", 8'(n_start), 8'd1);
    check("R7 ack captured", {7'h0, ack_rx_o}, 8'h00);
    check("R4 scl held low", {7'h0, scl_o}, 8'h00);
    repeat (60) @(negedge clk);
    check("R4 still waiting", {7'h0, wait_o}, 8'h01);

    // R4: resume with data byte
    send(8'h3C, 8'h01);
    wait_stall("R4");
    check("R7 ack on data", {7'h0, ack_rx_o}, 8'h00);

    // R7: slave NACKs
    sl_nack = 1;
    send(8'h81, 8'h01);
    wait_stall("R7");
    check("R7 nack captured", {7'h0, ack_rx_o}, 8'h01);
    sl_nack = 0;

    // R6 + R8: repeated start to a read address
    sl_tx_q.push_back(8'h96);
    sl_tx_q.push_back(8'h5B);
    send(8'hA5, 8'h05);
    rd(1'b0, r);
    check("R6 restart bit reads 0", r, 8'h01);
    wait_stall("R6");
    check("R6 second start", 8'(n_start), 8'd2);

    wr(1'b0, 8'h01);
    wait_stall("R8");
    rd(1'b1, r);
    check("R8 first read byte", r, 8'h96);
    check("R9 master ack 0", {7'h0, mack}, 8'h00);

    wr(1'b0, 8'h81);
    wait_stall("R8b");
    rd(1'b1, r);
    check("R8 second read byte", r, 8'h5B);
    check("R9 master nack 1", {7'h0, mack}, 8'h01);
    rd(1'b0, r);
    check("R9 ack value stored", r, 8'h81);

    // R5: stop
    wr(1'b0, 8'h02);
    rd(1'b0, r);
    check("R5 run cleared, stop reads 0", r, 8'h00);
    wait_idle("R5");
    check("R5 stop seen", 8'(n_stop), 8'd1);
    check("R5 lines released", {6'h0, scl_o, sda_o}, 8'h03);

    // R11: stop + restart + run together
    send(8'hA4, 8'h01);
    wait_stall("R11");
    wr(1'b0, 8'h07);
    wait_idle("R11");
    repeat (20) @(negedge clk);
    check("R11 stop taken", 8'(n_stop), 8'd2);
    check("R11 no restart", 8'(n_start), 8'd3);

    // R6: restart with run clear has no effect
    en = 1'b0;
    wr(1'b0, 8'h05);
    repeat (40) @(negedge clk);
    check("R6 ignored when run 0", {7'h0, busy_o}, 8'h00);
    check("R6 no start issued", 8'(n_start), 8'd3);
    en = 1'b1;

    // R10: abort mid-byte
    wr(1'b1, 8'hA4);
    wr(1'b0, 8'h01);
    repeat (40) @(negedge clk);
    wr(1'b0, 8'h00);
    check("R10 abort busy low", {7'h0, busy_o}, 8'h00);
    check("R10 abort lines released", {6'h0, scl_o, sda_o}, 8'h03);
    rd(1'b0, r);
    check("R10 run cleared", r, 8'h00);
    repeat (40) @(negedge clk);
    check("R2 scoreboard drained", 8'(exp_q.size()), 8'd0);
    report();
  end
endmodule